// File: doc/BRIEF.md
# Timestamped Sample Packet Framer

The framer gathers 16-bit samples from a set of up to four enabled channels and assembles them into fixed 256-byte frames. Each frame opens with a header byte and the 32-bit microsecond time at which its first sample was taken. The samples follow, two bytes each. The frame leaves the block as four 64-byte packets on a byte stream with a valid/ready handshake and an end-of-packet marker. Two frame stores alternate. One is filled by capture while the other is sent out. When the filling store completes its frame, the two swap roles.

A small command decoder takes 5-byte control messages. The first byte is an opcode. The other four bytes name the channels to enable, and slots that are not used hold a filler code. Samples are taken in a strict rotation over the enabled channels, lowest number first. Samples from any other channel, and samples that arrive out of turn, are ignored. When both stores hold complete frames and a sample that is due arrives, that sample is lost and a sticky overflow flag goes high.

Top module: `sample_frame_packer`

## Requirements
- R1: After reset `tx_valid` and `overflow` are 0, and no sample is captured until a start command has been applied.
- R2: A command is 5 bytes on `cmd_valid`/`cmd_byte`. Byte 0 is the opcode: 0x01 starts capture, 0x02 stops it, and any other opcode has no effect. Bytes 1 to 4 each hold a channel number 0 to 3, or the filler 0xFF. A start sets the enabled set to the listed channels. A start whose list is empty has no effect.
- R3: The expected channel begins at the lowest enabled channel when a start is applied. After each accepted sample it moves to the next higher enabled channel, wrapping around. A sample is accepted only when `smp_chan` equals the expected channel.
- R4: Frame byte 0 is 0xA5. Bytes 1 to 4 hold the timestamp, least significant byte first, taken from `ts_us` in the cycle the first sample was accepted. Then come N samples of 2 bytes each, least significant byte first, in acceptance order. All remaining bytes up to 255 are 0.
- R5: Each frame is sent as 256 bytes. `tx_last` is 1 on bytes 63, 127, 191 and 255, and 0 on all other bytes.
- R6: A byte is consumed only when `tx_valid` and `tx_ready` are both 1. While the output is stalled, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: A frame becomes ready after N accepted samples. Capture continues into the other store while that frame drains, and frames leave in the order they were completed.
- R8: If a due sample arrives while both stores hold full frames, it is dropped. The rotation does not advance, the queued frames are unchanged, and `overflow` becomes 1 and stays 1 until reset.
- R9: The timestamp is an unsigned 32-bit value that may wrap. Values near and at 0xFFFFFFFF are carried into the frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_us | input | 32 | Free-running microsecond time |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 2 | Channel number of the sample |
| smp_data | input | 16 | Sample value |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command message byte |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte available |
| tx_last | output | 1 | Last byte of a 64-byte packet |
| overflow | output | 1 | Sticky sample-loss flag |

## Verification
The hardest case to reach is a drop. A drop happens only when a due sample arrives while both stores hold finished frames. The stimulus gets there by holding `tx_ready` low for a long time, filling two whole frames, and then offering exactly the channel the rotation expects. The bench then releases the output and confirms that both queued frames come out intact and that `overflow` stays set. The stall pattern with gaps in `tx_ready` exercises hold-while-stalled. The rotation is tested with channel streams that repeatedly offer disabled and out-of-turn channels.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int CHANS       = 4;
  localparam int FRAME_BYTES = 256;
  localparam int PKT_BYTES   = 64;
  localparam int HDR_BYTES   = 5;
  localparam int MSG_LEN     = 5;

  localparam logic [7:0] OP_START  = 8'h01;
  localparam logic [7:0] OP_STOP   = 8'h02;
  localparam logic [7:0] SLOT_NOP  = 8'hFF;
  localparam logic [7:0] HDR_DATA  = 8'hA5;

  // next enabled channel strictly after cur, wrapping; cur itself if it is the only one
  function automatic logic [1:0] next_chan(input logic [3:0] mask, input logic [1:0] cur);
    logic [1:0] c;
    next_chan = cur;
    for (int i = CHANS; i >= 1; i--) begin
      c = cur + 2'(i);
      if (mask[c]) next_chan = c;
    end
  endfunction

  // sample word index addressed by a frame byte position, clamped into the store
  function automatic int word_of(input logic [7:0] idx, input int n);
    int k;
    k = int'(idx);
    word_of = (k < HDR_BYTES) ? 0 : (k - HDR_BYTES) / 2;
    if (word_of > n - 1) word_of = n - 1;
  endfunction

  // byte at frame position idx given the frame timestamp and the addressed word
  function automatic logic [7:0] frame_byte(input logic [7:0] idx, input logic [31:0] ts,
                                            input logic [15:0] word, input int n);
    int k;
    k = int'(idx);
    if (k == 0)                         frame_byte = HDR_DATA;
    else if (k < HDR_BYTES)             frame_byte = ts[8*(k-1) +: 8];
    else if (k < HDR_BYTES + 2*n)       frame_byte = ((k - HDR_BYTES) % 2 == 1) ? word[15:8] : word[7:0];
    else                                frame_byte = 8'h00;
  endfunction
endpackage

// File: rtl/sfp_cmd_decoder.sv
module sfp_cmd_decoder
  import sfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       run,
  output logic [3:0] mask,
  output logic       start_pulse
);
  logic [2:0] cnt;
  logic [7:0] op;
  logic [3:0] sel_acc;
  logic [3:0] sel_next;
  logic       cmd_apply;

  assign sel_next  = sel_acc | ((cmd_byte < 8'd4) ? (4'b0001 << cmd_byte[1:0]) : 4'b0000);
  assign cmd_apply = cmd_valid && (cnt == 3'(MSG_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; op <= '0; sel_acc <= '0;
      run <= 1'b0; mask <= '0; start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (cmd_valid) begin
        if (cnt == 3'd0) begin
          op      <= cmd_byte;
          sel_acc <= '0;
          cnt     <= 3'd1;
        end else if (cmd_apply) begin
          cnt <= 3'd0;
          if (op == OP_START && sel_next != 4'b0000) begin
            mask        <= sel_next;
            run         <= 1'b1;
            start_pulse <= 1'b1;
          end else if (op == OP_STOP) begin
            run <= 1'b0;
          end
        end else begin
          sel_acc <= sel_next;
          cnt     <= cnt + 3'd1;
        end
      end
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_apply |=> $stable(mask)); // R2
endmodule

// File: rtl/sfp_capture.sv
module sfp_capture
  import sfp_pkg::*;
#(
  parameter int N = 124
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [1:0]            smp_chan,
  input  logic [15:0]           smp_data,
  input  logic [31:0]           ts_us,
  input  logic                  run,
  input  logic [3:0]            mask,
  input  logic                  start_pulse,
  input  logic                  rel_valid,
  input  logic                  rd_sel,
  input  logic [$clog2(N)-1:0]  rd_word,
  output logic [1:0]            full,
  output logic [15:0]           rd_data,
  output logic [31:0]           rd_ts,
  output logic                  overflow
);
  localparam int IW = $clog2(N);

  logic [15:0]   mem [2][N];
  logic [31:0]   ts_q [2];
  logic          fill_sel;
  logic [IW-1:0] fill_cnt;
  logic [1:0]    exp_ch;
  logic [1:0]    exp_eff;
  logic          smp_hit, smp_write, smp_drop, frame_done;

  assign exp_eff    = start_pulse ? next_chan(mask, 2'd3) : exp_ch;
  assign smp_hit    = smp_valid && run && mask[smp_chan] && (smp_chan == exp_eff);
  assign smp_write  = smp_hit && !full[fill_sel];
  assign smp_drop   = smp_hit && full[fill_sel];
  assign frame_done = smp_write && (fill_cnt == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (smp_write) mem[fill_sel][fill_cnt] <= smp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q[0] <= '0; ts_q[1] <= '0;
      full <= '0; fill_sel <= 1'b0; fill_cnt <= '0;
      exp_ch <= '0; overflow <= 1'b0;
    end else begin
      if (start_pulse) exp_ch <= exp_eff;
      if (rel_valid) full[rd_sel] <= 1'b0;
      if (smp_drop) overflow <= 1'b1;
      if (smp_write) begin
        exp_ch <= next_chan(mask, smp_chan);
        if (fill_cnt == '0) ts_q[fill_sel] <= ts_us;
        if (frame_done) begin
          full[fill_sel] <= 1'b1;
          fill_sel       <= ~fill_sel;
          fill_cnt       <= '0;
        end else begin
          fill_cnt <= fill_cnt + 1'b1;
        end
      end
    end
  end

  assign rd_data = mem[rd_sel][rd_word];
  assign rd_ts   = ts_q[rd_sel];

  AST_DROP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_drop |-> (full == 2'b11)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_WRITE_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_write && full[rd_sel]) |-> (fill_sel != rd_sel)); // R7
endmodule

// File: rtl/sfp_tx.sv
module sfp_tx
  import sfp_pkg::*;
#(
  parameter int N = 124
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            full,
  input  logic [15:0]           rd_data,
  input  logic [31:0]           rd_ts,
  input  logic                  tx_ready,
  output logic                  rd_sel,
  output logic [$clog2(N)-1:0]  rd_word,
  output logic                  rel_valid,
  output logic [7:0]            tx_data,
  output logic                  tx_valid,
  output logic                  tx_last
);
  localparam int IW = $clog2(N);
  localparam logic [7:0] LAST_IDX = 8'(FRAME_BYTES - 1);
  localparam logic [5:0] PKT_END  = 6'(PKT_BYTES - 1);

  logic [7:0] idx;
  logic       beat;

  assign tx_valid  = full[rd_sel];
  assign beat      = tx_valid && tx_ready;
  assign rel_valid = beat && (idx == LAST_IDX);
  assign rd_word   = IW'(word_of(idx, N));
  assign tx_data   = frame_byte(idx, rd_ts, rd_data, N);
  assign tx_last   = tx_valid && (idx[5:0] == PKT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; rd_sel <= 1'b0;
    end else if (beat) begin
      idx <= idx + 8'd1;
      if (idx == LAST_IDX) rd_sel <= ~rd_sel;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> tx_last); // R5
endmodule

// File: rtl/sample_frame_packer.sv
module sample_frame_packer
  import sfp_pkg::*;
#(
  parameter int N = 124
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ts_us,
  input  logic        smp_valid,
  input  logic [1:0]  smp_chan,
  input  logic [15:0] smp_data,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  output logic        overflow
);
  localparam int IW = $clog2(N);

  logic          run, start_pulse, rel_valid, rd_sel;
  logic [3:0]    mask;
  logic [1:0]    full;
  logic [15:0]   rd_data;
  logic [31:0]   rd_ts;
  logic [IW-1:0] rd_word;

  sfp_cmd_decoder u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .run(run), .mask(mask), .start_pulse(start_pulse)
  );

  sfp_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .ts_us(ts_us), .run(run), .mask(mask),
    .start_pulse(start_pulse), .rel_valid(rel_valid), .rd_sel(rd_sel),
    .rd_word(rd_word), .full(full), .rd_data(rd_data), .rd_ts(rd_ts),
    .overflow(overflow)
  );

  sfp_tx #(.N(N)) u_tx (
    .clk(clk), .rst_n(rst_n), .full(full), .rd_data(rd_data), .rd_ts(rd_ts),
    .tx_ready(tx_ready), .rd_sel(rd_sel), .rd_word(rd_word),
    .rel_valid(rel_valid), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last)
  );
endmodule

// File: tb/test_sample_frame_packer.sv
module test_sample_frame_packer;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ts_us = '0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [15:0] smp_data = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, overflow;

  always #10 clk = ~clk;

  sample_frame_packer #(.N(NS)) i_sample_frame_packer (
    .clk(clk), .rst_n(rst_n), .ts_us(ts_us), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  logic [7:0]  q_exp[$];
  logic [15:0] m_words[$];
  logic [31:0] m_ts;
  logic [3:0]  m_mask = '0;
  logic [1:0]  m_exp = '0;
  bit          m_run = 0, m_block = 0, done = 0;
  int          frames = 0, rdy_mode = 0, cyc = 0, pos = 0;
  bit          was_stall = 0;
  logic [7:0]  held_d;
  logic        held_l;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // rotation written from R3: scan upward from cur+1, wrap, first enabled wins
  function automatic logic [1:0] rot_after(input logic [3:0] m, input logic [1:0] cur);
    for (int d = 1; d <= 4; d++) if (m[(cur + d) % 4]) return 2'((cur + d) % 4);
    return cur;
  endfunction

  task automatic push_frame();
    int n = 0;
    q_exp.push_back(8'hA5); n++;
    for (int b = 0; b < 4; b++) begin q_exp.push_back(m_ts[8*b +: 8]); n++; end
    foreach (m_words[w]) begin
      q_exp.push_back(m_words[w][7:0]); q_exp.push_back(m_words[w][15:8]); n += 2;
    end
    while (n < 256) begin q_exp.push_back(8'h00); n++; end
    m_words.delete();
    frames++;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [7:0] s0, input logic [7:0] s1,
                          input logic [7:0] s2, input logic [7:0] s3);
    logic [7:0] b [5];
    logic [3:0] nm = '0;
    b[0] = op; b[1] = s0; b[2] = s1; b[3] = s2; b[4] = s3;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); cmd_valid = 1'b1; cmd_byte = b[i];
      if (i > 0 && b[i] < 4) nm[b[i][1:0]] = 1'b1;
    end
    @(negedge clk); cmd_valid = 1'b0;
    if (op == 8'h01 && nm != 0) begin
      m_mask = nm; m_run = 1; m_exp = rot_after(nm, 2'd3);
    end else if (op == 8'h02) m_run = 0;
  endtask

  task automatic send_sample(input logic [1:0] ch, input logic [15:0] d, input logic [31:0] t);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d; ts_us = t;
    @(negedge clk);
    smp_valid = 1'b0;
    if (m_run && m_mask[ch] && ch == m_exp && !m_block) begin
      if (m_words.size() == 0) m_ts = t;
      m_words.push_back(d);
      m_exp = rot_after(m_mask, ch);
      if (m_words.size() == NS) push_frame();
    end
  endtask

  task automatic fill_frames(input int n, input int mul, input logic [31:0] tbase, input logic [15:0] dbase);
    int target = frames + n;
    for (int k = 0; k < 2000 && frames < target; k++)
      send_sample(2'((k * mul + 1) % 4), dbase + 16'(k * 16'h0111), tbase + 32'(k));
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 4000 && q_exp.size() != 0; i++) @(negedge clk);
    chk(q_exp.size() == 0, "R7", "bytes left undelivered", q_exp.size(), 0);
  endtask

  // monitor: owns tx_ready, pops expected bytes on every handshake
  always @(negedge clk) begin
    logic r;
    logic [7:0] e;
    if (was_stall)
      chk(tx_valid && tx_data == held_d && tx_last == held_l, "R6", "stalled output moved",
          {tx_valid, tx_data}, {1'b1, held_d});
    case (rdy_mode)
      0: r = 1'b1;
      1: r = (cyc % 3 != 2);
      default: r = 1'b0;
    endcase
    cyc++;
    tx_ready = r;
    if (rst_n && tx_valid && r) begin
      if (q_exp.size() == 0) chk(0, "R7", "unexpected byte", tx_data, 0);
      else begin
        e = q_exp.pop_front();
        chk(tx_data == e, "R4", $sformatf("frame byte %0d", pos), tx_data, e);
        chk(tx_last == (pos % 64 == 63), "R5", $sformatf("last flag at %0d", pos), tx_last, pos % 64 == 63);
        pos = (pos + 1) % 256;
      end
    end
    was_stall = rst_n && tx_valid && !r;
    held_d = tx_data; held_l = tx_last;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R7", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    for (int i = 0; i < 4; i++) send_sample(2'(i), 16'hDEAD, 32'h5);
    chk(tx_valid == 1'b0, "R1", "capture before start", tx_valid, 0);

    // R2 R3 R9: channels {0,2} listed out of order, mixed stream, timestamps straddle wrap
    send_cmd(8'h01, 8'd2, 8'd0, 8'hFF, 8'hFF);
    fill_frames(1, 3, 32'hFFFF_FFFD, 16'hA000);
    wait_drain();

    // R6: gappy ready, channels {1,3}
    rdy_mode = 1;
    send_cmd(8'h01, 8'd3, 8'hFF, 8'd1, 8'hFF);
    fill_frames(1, 1, 32'hFFFF_FFFF, 16'h1200);
    wait_drain();

    // R7 R8: stall output, fill both stores, then offer a due sample
    rdy_mode = 2;
    fill_frames(2, 1, 32'h0012_3400, 16'h3300);
    chk(tx_valid == 1'b1, "R7", "frame ready", tx_valid, 1);
    chk(overflow == 1'b0, "R8", "no overflow with two frames", overflow, 0);
    m_block = 1;
    send_sample(m_exp, 16'hBAD0, 32'h0);
    m_block = 0;
    chk(overflow == 1'b1, "R8", "overflow after drop", overflow, 1);
    rdy_mode = 0;
    wait_drain();
    chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
    fill_frames(1, 1, 32'h0000_1000, 16'h4400);
    wait_drain();

    // R2: stop, then an unknown opcode must not change the enabled set
    send_cmd(8'h02, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    for (int i = 0; i < 2 * NS; i++) send_sample(2'(i % 4), 16'hBEEF, 32'h7);
    repeat (2) @(negedge clk);
    chk(tx_valid == 1'b0, "R2", "samples after stop", tx_valid, 0);
    send_cmd(8'h01, 8'hFF, 8'hFF, 8'hFF, 8'd3);
    send_cmd(8'h07, 8'd1, 8'hFF, 8'hFF, 8'hFF);
    fill_frames(1, 1, 32'h0ABC_0000, 16'h5500);
    wait_drain();

    chk(m_words.size() == 0, "R3", "partial frame left in model", m_words.size(), 0);
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R7", "idle at end", tx_valid, 0);
    summary();
  end
endmodule